// File: doc/BRIEF.md
# Predicated Vector Rounding Shift Unit

The unit works on a vector of unsigned 64-bit lanes. Each lane has its own signed shift amount and its own predicate bit. A lane with a zero or positive amount shifts its data left. A lane with a negative amount shifts its data right and rounds to nearest. Before the right shift, a bias of half of the last kept bit is added, so ties round upward.

Lanes whose predicate bit is clear return their input data unchanged. The result is a merged update of the first operand.

One input beat is accepted per cycle. The result appears on a registered output beat one clock later. All lanes are computed in parallel. The vector width is a parameter: a multiple of 128 bits, from 128 to 2048.

Top module: `vec_rshift_unit`

## Requirements
- R1: Lane i occupies bits [64i+63:64i] of the data, shift and result vectors. For an amount a from 0 to 63, an active lane returns data << a, truncated to 64 bits.
- R2: For an amount a from -1 to -64, an active lane returns (data + 2^(-a-1)) >> -a. The sum is formed in 65 bits, so all-ones data with a = -1 gives 2^63. Ties round upward.
- R3: The amount is the two's-complement value of bits [7:0] of the lane's shift element. Bits [63:8] have no effect on the result.
- R4: For an amount from 64 to 127, an active lane returns zero.
- R5: For an amount from -65 to -128, an active lane returns zero.
- R6: For an amount of -64, an active lane returns data bit 63. The result is 1 when that bit is set and 0 when it is clear.
- R7: For an amount of 0, an active lane returns its data unchanged.
- R8: Lane i is active when in_pred[i] is 1. An inactive lane returns its input data, whatever its shift element holds.
- R9: out_valid equals in_valid from the previous clock. out_data carries the result of the beat captured on that edge.
- R10: When synchronous active-high reset is applied, out_valid and out_data are 0 after the next edge.
- R11: Each lane's result depends only on that lane's own data, shift and predicate. Lanes with different amounts in one beat are all correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_data | input | VEC_BITS | Unsigned data lanes |
| in_shift | input | VEC_BITS | Signed shift element per lane |
| in_pred | input | VEC_BITS/64 | Per-lane predicate, 1 = active |
| out_valid | output | 1 | Result beat valid |
| out_data | output | VEC_BITS | Merged result lanes |

## Verification
Every result is due exactly one clock edge after the beat is presented. There is a single register stage between the input and output ports. The bench drives each beat on a falling edge, lets the next rising edge capture it, and compares out_valid and every lane on the following falling edge. Idle cycles are checked the same way, to confirm that out_valid drops one edge after in_valid drops. Reset is checked one edge after it is applied.

// File: rtl/vec_rshift_unit.sv
module vec_rshift_unit #(
  parameter int VEC_BITS = 256
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [VEC_BITS-1:0]       in_data,
  input  logic [VEC_BITS-1:0]       in_shift,
  input  logic [VEC_BITS/64-1:0]    in_pred,
  output logic                      out_valid,
  output logic [VEC_BITS-1:0]       out_data
);
  localparam int LANES = VEC_BITS / 64;

  function automatic logic [63:0] lane_op(input logic [63:0] d, input logic signed [7:0] a);
    logic [7:0]  n;
    logic [64:0] sum;
    if (a >= 8'sd0) begin
      lane_op = (a >= 8'sd64) ? 64'd0 : (d << a[5:0]);
    end else begin
      n = 8'(-a);
      if (n > 8'd64) begin
        lane_op = 64'd0;
      end else begin
        sum     = {1'b0, d} + (65'd1 << (n - 8'd1));
        lane_op = 64'(sum >> n);
      end
    end
  endfunction

  logic [VEC_BITS-1:0] next_data;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [63:0]       d   = in_data[64*i +: 64];
    wire signed [7:0] amt = in_shift[64*i +: 8];
    assign next_data[64*i +: 64] = in_pred[i] ? lane_op(d, amt) : d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_data;
    end
  end
endmodule

module vec_rshift_unit_chk #(
  parameter int VEC_BITS = 256
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [VEC_BITS-1:0]    in_data,
  input logic [VEC_BITS-1:0]    in_shift,
  input logic [VEC_BITS/64-1:0] in_pred,
  input logic                   out_valid,
  input logic [VEC_BITS-1:0]    out_data
);
  localparam int LANES = VEC_BITS / 64;

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_merge_inactive_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_pred[i]) |=> out_data[64*i +: 64] == $past(in_data[64*i +: 64]));
    assert_zero_amount_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_pred[i] && in_shift[64*i +: 8] == 8'd0)
        |=> out_data[64*i +: 64] == $past(in_data[64*i +: 64]));
    assert_left_flush_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_pred[i] && in_shift[64*i+7 -: 2] == 2'b01)
        |=> out_data[64*i +: 64] == 64'd0);
    assert_right_flush_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_pred[i] && $signed(in_shift[64*i +: 8]) <= -8'sd65)
        |=> out_data[64*i +: 64] == 64'd0);
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_data));
  end
endmodule

bind vec_rshift_unit vec_rshift_unit_chk #(.VEC_BITS(VEC_BITS)) u_chk (.*);

// File: tb/vec_rshift_unit_tb.sv
module vec_rshift_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_BITS   = 256;
  localparam int LANES      = VEC_BITS / 64;

  typedef struct packed {
    logic [63:0] d;
    logic [63:0] s;
    logic [63:0] e;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{64'd1, 64'd3, 64'd8},                                                    // R1
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000}, // R2
    '{64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3},                                  // R2 tie
    '{64'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2},                                  // R2
    '{64'd6, 64'hFFFF_FFFF_FFFF_FFFE, 64'd2},                                  // R2 tie
    '{64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 64'd1},                                  // R2
    '{64'd1, 64'd63, 64'h8000_0000_0000_0000},                                 // R1
    '{64'd1, 64'd64, 64'd0},                                                   // R4
    '{64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFC0, 64'd1},                // R6
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFC0, 64'd0},                // R6
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFBF, 64'd0},                // R5
    '{64'h1234, 64'd0, 64'h1234},                                              // R7
    '{64'd3, 64'h0000_0100_0000_0002, 64'd12},                                 // R3
    '{64'd2, 64'hABCD_0000_0000_00FF, 64'd1},                                  // R3
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd127, 64'd0},                                // R4
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FF80, 64'd0}                 // R5
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic [VEC_BITS-1:0] in_data = '0;
  logic [VEC_BITS-1:0] in_shift = '0;
  logic [LANES-1:0]    in_pred = '0;
  logic                out_valid;
  logic [VEC_BITS-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_rshift_unit #(.VEC_BITS(VEC_BITS)) u_dut (.*);

  function automatic logic [63:0] ref_lane(input logic [63:0] d, input logic [63:0] s, input bit act);
    int a;
    logic [64:0] q;
    a = int'($signed(s[7:0]));
    if (!act) return d;
    if (a >= 64) return 64'd0;
    if (a >= 0) return d << a;
    if (-a - 1 >= 64) return 64'd0;
    q = {1'b0, d >> (-a - 1)} + 65'd1;
    return q[64:1];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [VEC_BITS-1:0] d, input logic [VEC_BITS-1:0] s, input logic [LANES-1:0] p);
    @(negedge clk);
    in_data = d; in_shift = s; in_pred = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [VEC_BITS-1:0] d, s;
    logic [63:0] lfsr;
    repeat (2) @(negedge clk);
    check("R10 out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 out_data", out_data[63:0], 64'd0);
    rst = 1'b0;

    for (int b = 0; b < NV / LANES; b++) begin
      for (int l = 0; l < LANES; l++) begin
        d[64*l +: 64] = TBL[b*LANES + l].d;
        s[64*l +: 64] = TBL[b*LANES + l].s;
      end
      beat(d, s, '1);
      check("R9 valid", {63'd0, out_valid}, 64'd1);
      for (int l = 0; l < LANES; l++)
        check("R1-table", out_data[64*l +: 64], TBL[b*LANES + l].e);
    end

    @(negedge clk);
    check("R9 idle", {63'd0, out_valid}, 64'd0);

    for (int l = 0; l < LANES; l++) begin
      d[64*l +: 64] = 64'hF0F0_0000_0000_0F0F + 64'(l);
      s[64*l +: 64] = 64'd4;
    end
    beat(d, s, 4'b0101);
    for (int l = 0; l < LANES; l++)
      check("R8 merge", out_data[64*l +: 64], (l % 2 == 0) ? (d[64*l +: 64] << 4) : d[64*l +: 64]);

    lfsr = 64'hACE1_2468_1357_9BDF;
    for (int t = 0; t < 40; t++) begin
      for (int l = 0; l < LANES; l++) begin
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        d[64*l +: 64] = lfsr;
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        s[64*l +: 64] = {lfsr[63:8], 8'(int'(lfsr[7:0]) % 140 - 70)};
      end
      beat(d, s, 4'(t));
      for (int l = 0; l < LANES; l++)
        check("R11 lane", out_data[64*l +: 64], ref_lane(d[64*l +: 64], s[64*l +: 64], t[l]));
    end

    @(negedge clk);
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset data", out_data[63:0], 64'd0);
    finish_run();
  end
endmodule